// File: doc/BRIEF.md
# Convolution Accelerator Bus Front End

This block sits between a Wishbone slave bus and a small convolution engine. One address window is cut into four equal regions: control words, an image buffer, a kernel buffer and a result buffer. Software fills the image and kernel buffers and writes two configuration words. It then sets the start bit and polls a done flag. To rearm the engine it clears start and pulses a soft reset.

The engine side is a set of plain pins. The configuration fields come out as registered values, exactly as software wrote them, with the count fields still coded as value minus one. `eng_start` is a one-cycle pulse and `eng_srst` is a level. There is one asynchronous read port each into the image and kernel buffers, and one write port into the result buffer. The engine raises `eng_done` for one or more cycles when it has finished.

The bus follows a request/acknowledge form of back-pressure. A master holds `wb_cyc` and `wb_stb` until it sees `wb_ack`. The block answers every request with exactly one acknowledge, one cycle later. If the request is still held during the acknowledge cycle, it is treated as a new request and answered again one cycle after that. There are no wait states, bursts or error responses.

Top module: `cnv_bus_front`

## Requirements
- R1: `wb_ack` rises in the cycle after `wb_cyc` and `wb_stb` are both sampled high with `wb_ack` low, and it stays high for exactly one cycle. Read data appears on `wb_dat_r` in that same acknowledge cycle. With `wb_stb` low, no acknowledge is given.
- R2: Address bits [9:8] select the region: 0 is control, 1 is image, 2 is kernel and 3 is result. Bits [7:2] give the word index. Bits [1:0] are ignored.
- R3: An image or kernel word keeps only bits [23:0] of the written data (three 8-bit channels). Reading it back returns zero in bits [31:24]. The engine read ports return the stored 24 bits combinationally.
- R4: Control word 1 holds the kernel column count in [2:0], the image columns in [15:8], the kernel count in [18:16] and the stride in [31:24]. Other bits read back as zero. The fields appear unchanged on their `cfg_*` pins.
- R5: Control word 2 holds the result columns in [7:0], the shift in [11:8], the kernel address mode in bit 16, the pooling enable in bit 17 and the channel mask in [20:18]. Other bits read back as zero. The fields appear on their `cfg_*` pins.
- R6: In control word 0, bit 2 is the start bit and reads back as written. A write that sets bit 2 while it was clear gives a one-cycle `eng_start` pulse in the acknowledge cycle. Writing bit 2 while it is already set gives no pulse.
- R7: Bit 0 of word 0 is the done flag. `eng_done` sets it, it holds until a soft reset, and bus writes to bit 0 have no effect.
- R8: Bit 1 of word 0 drives `eng_srst` from the acknowledge cycle on. While it is set, the done flag is cleared and `eng_done` is ignored.
- R9: The engine writes `eng_res_data` at `eng_res_addr` on a clock where `eng_res_we` is high. Bus reads of the result region return that value zero-extended. Bus writes to the result region are ignored.
- R10: Accesses with any address bit above 9 set, or to control word index 3 or higher, are acknowledged, read as zero and change nothing.
- R11: After reset, `wb_ack`, `wb_dat_r`, `eng_start`, `eng_srst`, the done flag, both configuration words and all `cfg_*` pins are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc | input | 1 | Bus cycle active |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | ADDR_W | Byte address |
| wb_dat_w | input | 32 | Write data |
| wb_ack | output | 1 | One-cycle acknowledge |
| wb_dat_r | output | 32 | Read data, valid with acknowledge |
| eng_done | input | 1 | Engine finished |
| eng_start | output | 1 | Start pulse |
| eng_srst | output | 1 | Soft reset level |
| cfg_kcols | output | 3 | Kernel columns minus one |
| cfg_cols | output | 8 | Image columns minus one |
| cfg_kerns | output | 3 | Kernel count minus one |
| cfg_stride | output | 8 | Stride |
| cfg_rcols | output | 8 | Result columns minus one |
| cfg_shift | output | 4 | Output shift |
| cfg_kmode | output | 1 | Kernel address mode |
| cfg_pool | output | 1 | Pooling enable |
| cfg_mask | output | 3 | Channel mask |
| eng_img_addr | input | IDX_W | Engine image read index |
| eng_img_data | output | 24 | Image word at that index |
| eng_krn_addr | input | IDX_W | Engine kernel read index |
| eng_krn_data | output | 24 | Kernel word at that index |
| eng_res_we | input | 1 | Result write enable |
| eng_res_addr | input | IDX_W | Result write index |
| eng_res_data | input | RES_W | Result write data |

## Verification
The bench holds a request through its acknowledge cycle. A design that acknowledged a level instead of a new request would answer twice in a row, or not at all.

It writes the start bit again while it is already set and expects no second pulse. A design that pulses on every write would restart the engine part way through a run. It raises `eng_done` while soft reset is held and writes a 1 to the done bit. A design that latched either would report completion falsely.

It writes random top bytes into buffer words, hits the result region and unmapped addresses with writes, and then reads everything back. A design that stored the padding byte, or decoded only the low address bits, would show aliased or corrupted data.

// File: rtl/cnv_pkg.sv
package cnv_pkg;
  typedef enum logic [1:0] {
    WIN_REG = 2'd0,
    WIN_IMG = 2'd1,
    WIN_KRN = 2'd2,
    WIN_RES = 2'd3
  } win_e;

  localparam int DATA_W   = 32;
  localparam int CH_W     = 8;
  localparam int NUM_CH   = 3;
  localparam int PIX_W    = CH_W * NUM_CH;
  localparam int NUM_REGS = 3;

  typedef struct packed {
    logic [7:0] stride;
    logic [2:0] kerns;
    logic [7:0] cols;
    logic [2:0] kcols;
  } geom_t;

  typedef struct packed {
    logic [2:0] mask;
    logic       pool;
    logic       kmode;
    logic [3:0] shift;
    logic [7:0] rcols;
  } mode_t;
endpackage

// File: rtl/cnv_addr_map.sv
module cnv_addr_map
  import cnv_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] adr,
  output win_e              win,
  output logic [IDX_W-1:0]  idx,
  output logic              hit
);
  localparam int SEL_LO = IDX_W + 2;

  logic upper_ok;
  logic unused_lsb;

  assign unused_lsb = ^adr[1:0];
  assign win = win_e'(adr[SEL_LO+1:SEL_LO]);
  assign idx = adr[SEL_LO-1:2];

  generate
    if (ADDR_W > SEL_LO + 2) begin : g_upper
      assign upper_ok = ~|adr[ADDR_W-1:SEL_LO+2];
    end else begin : g_no_upper
      assign upper_ok = 1'b1;
    end
  endgenerate

  assign hit = upper_ok && ((win != WIN_REG) || (idx < IDX_W'(NUM_REGS)));
endmodule

// File: rtl/cnv_word_buf.sv
module cnv_word_buf #(
  parameter int W     = 24,
  parameter int DEPTH = 64,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [W-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rdata[p] = mem[raddr[p]];
    end
  endgenerate
endmodule

// File: rtl/cnv_ctl_regs.sv
module cnv_ctl_regs
  import cnv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        widx,
  input  logic [DATA_W-1:0] wdat,
  input  logic [1:0]        ridx,
  output logic [DATA_W-1:0] rdat,
  input  logic              eng_done,
  output logic              eng_start,
  output logic              eng_srst,
  output geom_t             geom,
  output mode_t             mode
);
  logic  start_q, srst_q, done_q;
  geom_t geom_q;
  mode_t mode_q;
  logic  unused_hi;

  assign unused_hi = ^wdat[23:21];

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= 1'b0;
      srst_q    <= 1'b0;
      done_q    <= 1'b0;
      eng_start <= 1'b0;
      geom_q    <= '0;
      mode_q    <= '0;
    end else begin
      eng_start <= 1'b0;
      if (wr_en && widx == 2'd0) begin
        start_q   <= wdat[2];
        srst_q    <= wdat[1];
        eng_start <= wdat[2] & ~start_q;
      end
      if (wr_en && widx == 2'd1)
        geom_q <= {wdat[31:24], wdat[18:16], wdat[15:8], wdat[2:0]};
      if (wr_en && widx == 2'd2)
        mode_q <= {wdat[20:18], wdat[17], wdat[16], wdat[11:8], wdat[7:0]};
      if (srst_q)        done_q <= 1'b0;
      else if (eng_done) done_q <= 1'b1;
    end
  end

  always_comb begin
    rdat = '0;
    case (ridx)
      2'd0: rdat = {29'd0, start_q, srst_q, done_q};
      2'd1: rdat = {geom_q.stride, 5'd0, geom_q.kerns, geom_q.cols, 5'd0, geom_q.kcols};
      2'd2: rdat = {11'd0, mode_q.mask, mode_q.pool, mode_q.kmode, 4'd0,
                    mode_q.shift, mode_q.rcols};
      default: rdat = '0;
    endcase
  end

  assign eng_srst = srst_q;
  assign geom     = geom_q;
  assign mode     = mode_q;

  // R7: done only rises after the engine reported completion
  p_done_source_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(eng_done));

  // R8: while soft reset is held the done flag drops
  p_srst_clears_done_r8: assert property (@(posedge clk) disable iff (rst)
    (srst_q && $past(srst_q)) |-> !done_q);

  // R6: start is a single-cycle pulse
  p_start_single_r6: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  // R4 and R5: configuration changes only on a bus write
  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(geom_q) && $stable(mode_q)));
endmodule

// File: rtl/cnv_bus_front.sv
module cnv_bus_front
  import cnv_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BUF_WORDS = 64,
  parameter int RES_W     = 8,
  localparam int IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc,
  input  logic              wb_stb,
  input  logic              wb_we,
  input  logic [ADDR_W-1:0] wb_adr,
  input  logic [31:0]       wb_dat_w,
  output logic              wb_ack,
  output logic [31:0]       wb_dat_r,
  input  logic              eng_done,
  output logic              eng_start,
  output logic              eng_srst,
  output logic [2:0]        cfg_kcols,
  output logic [7:0]        cfg_cols,
  output logic [2:0]        cfg_kerns,
  output logic [7:0]        cfg_stride,
  output logic [7:0]        cfg_rcols,
  output logic [3:0]        cfg_shift,
  output logic              cfg_kmode,
  output logic              cfg_pool,
  output logic [2:0]        cfg_mask,
  input  logic [IDX_W-1:0]  eng_img_addr,
  output logic [23:0]       eng_img_data,
  input  logic [IDX_W-1:0]  eng_krn_addr,
  output logic [23:0]       eng_krn_data,
  input  logic              eng_res_we,
  input  logic [IDX_W-1:0]  eng_res_addr,
  input  logic [RES_W-1:0]  eng_res_data
);
  win_e                    win;
  logic [IDX_W-1:0]        idx;
  logic                    hit, req, bus_wr;
  logic [DATA_W-1:0]       reg_rd, rd_mux;
  logic [1:0][PIX_W-1:0]   img_rd, krn_rd;
  logic [0:0][RES_W-1:0]   res_rd;
  geom_t                   geom;
  mode_t                   mode;

  assign req    = wb_cyc & wb_stb & ~wb_ack;
  assign bus_wr = req & wb_we & hit;

  cnv_addr_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_map (
    .adr(wb_adr), .win(win), .idx(idx), .hit(hit));

  cnv_ctl_regs i_regs (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr && win == WIN_REG), .widx(idx[1:0]), .wdat(wb_dat_w),
    .ridx(idx[1:0]), .rdat(reg_rd),
    .eng_done(eng_done), .eng_start(eng_start), .eng_srst(eng_srst),
    .geom(geom), .mode(mode));

  cnv_word_buf #(.W(PIX_W), .DEPTH(BUF_WORDS), .NRD(2)) i_img (
    .clk(clk), .we(bus_wr && win == WIN_IMG), .waddr(idx),
    .wdata(wb_dat_w[PIX_W-1:0]), .raddr({eng_img_addr, idx}), .rdata(img_rd));

  cnv_word_buf #(.W(PIX_W), .DEPTH(BUF_WORDS), .NRD(2)) i_krn (
    .clk(clk), .we(bus_wr && win == WIN_KRN), .waddr(idx),
    .wdata(wb_dat_w[PIX_W-1:0]), .raddr({eng_krn_addr, idx}), .rdata(krn_rd));

  cnv_word_buf #(.W(RES_W), .DEPTH(BUF_WORDS), .NRD(1)) i_res (
    .clk(clk), .we(eng_res_we), .waddr(eng_res_addr),
    .wdata(eng_res_data), .raddr(idx), .rdata(res_rd));

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      unique case (win)
        WIN_REG: rd_mux = reg_rd;
        WIN_IMG: rd_mux = {{(DATA_W-PIX_W){1'b0}}, img_rd[0]};
        WIN_KRN: rd_mux = {{(DATA_W-PIX_W){1'b0}}, krn_rd[0]};
        WIN_RES: rd_mux = {{(DATA_W-RES_W){1'b0}}, res_rd[0]};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_ack   <= 1'b0;
      wb_dat_r <= '0;
    end else begin
      wb_ack   <= req;
      wb_dat_r <= (req && !wb_we) ? rd_mux : '0;
    end
  end

  assign eng_img_data = img_rd[1];
  assign eng_krn_data = krn_rd[1];
  assign cfg_kcols    = geom.kcols;
  assign cfg_cols     = geom.cols;
  assign cfg_kerns    = geom.kerns;
  assign cfg_stride   = geom.stride;
  assign cfg_rcols    = mode.rcols;
  assign cfg_shift    = mode.shift;
  assign cfg_kmode    = mode.kmode;
  assign cfg_pool     = mode.pool;
  assign cfg_mask     = mode.mask;

  p_ack_single_r1: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack);

  p_ack_answers_r1: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && wb_stb && !wb_ack) |=> wb_ack);

  p_ack_needs_req_r1: assert property (@(posedge clk) disable iff (rst)
    wb_ack |-> $past(wb_cyc && wb_stb));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (req && !hit && !wb_we) |=> (wb_dat_r == '0));
endmodule

// File: tb/test_cnv_bus_front.sv
module test_cnv_bus_front;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] M1 = 32'hFF07_FF07;
  localparam logic [31:0] M2 = 32'h001F_0FFF;

  logic clk = 1'b0, rst = 1'b1;
  logic wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [11:0] wb_adr = '0;
  logic [31:0] wb_dat_w = '0;
  logic wb_ack;
  logic [31:0] wb_dat_r;
  logic eng_done = 0, eng_start, eng_srst;
  logic [2:0] cfg_kcols, cfg_kerns, cfg_mask;
  logic [7:0] cfg_cols, cfg_stride, cfg_rcols;
  logic [3:0] cfg_shift;
  logic cfg_kmode, cfg_pool;
  logic [5:0] eng_img_addr = '0, eng_krn_addr = '0, eng_res_addr = '0;
  logic [23:0] eng_img_data, eng_krn_data;
  logic eng_res_we = 0;
  logic [7:0] eng_res_data = '0;

  cnv_bus_front i_cnv_bus_front (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int ntot = 0, nfail = 0;
  logic [23:0] img_m [64];
  logic [23:0] krn_m [64];
  logic [7:0]  res_m [64];
  logic [31:0] w1_m = 0, w2_m = 0;
  logic st_m = 0, sr_m = 0, dn_m = 0;
  logic saw_start;
  logic [31:0] r;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  %0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    ntot++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    logic [5:0] ix = a[7:2];
    if (a[11:10] != 0) return 0;
    case (a[9:8])
      2'd0: return ix == 0 ? {29'd0, st_m, sr_m, dn_m} : ix == 1 ? w1_m : ix == 2 ? w2_m : 0;
      2'd1: return {8'd0, img_m[ix]};
      2'd2: return {8'd0, krn_m[ix]};
      default: return {24'd0, res_m[ix]};
    endcase
  endfunction

  task automatic bus(input bit we, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = a; wb_dat_w = d;
    @(negedge clk);
    chk(wb_ack === 1'b1, "R1 ack", {31'd0, wb_ack}, 1);
    r = wb_dat_r; saw_start = eng_start;
    wb_cyc = 0; wb_stb = 0; wb_we = 0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input string tag);
    logic [31:0] e = exp_rd(a);
    bus(0, a, 0);
    chk(r === e, tag, r, e);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [5:0] ix = a[7:2];
    bit pulse = 0, w0 = 0;
    if (a[11:10] == 0) begin
      case (a[9:8])
        2'd0: if (ix == 0) begin pulse = d[2] && !st_m; w0 = 1; st_m = d[2]; sr_m = d[1];
                                 if (d[1]) dn_m = 0; end
              else if (ix == 1) w1_m = d & M1;
              else if (ix == 2) w2_m = d & M2;
        2'd1: img_m[ix] = d[23:0];
        2'd2: krn_m[ix] = d[23:0];
        default: ;
      endcase
    end
    bus(1, a, d);
    if (w0) chk(saw_start === pulse, "R6 start pulse", {31'd0, saw_start}, {31'd0, pulse});
  endtask

  task automatic cfg_chk();
    chk({cfg_stride, 5'd0, cfg_kerns, cfg_cols, 5'd0, cfg_kcols} === w1_m, "R4 cfg pins",
        {cfg_stride, 5'd0, cfg_kerns, cfg_cols, 5'd0, cfg_kcols}, w1_m);
    chk({11'd0, cfg_mask, cfg_pool, cfg_kmode, 4'd0, cfg_shift, cfg_rcols} === w2_m, "R5 cfg pins",
        {11'd0, cfg_mask, cfg_pool, cfg_kmode, 4'd0, cfg_shift, cfg_rcols}, w2_m);
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
    if (!sr_m) dn_m = 1;
  endtask

  initial begin
    void'($urandom(32'h0C0FFEE5));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(wb_ack === 0 && wb_dat_r === 0, "R11 bus idle", wb_dat_r, 0);
    chk(eng_start === 0 && eng_srst === 0, "R11 engine controls", {30'd0, eng_start, eng_srst}, 0);
    cfg_chk();
    rd_chk(12'h000, "R11 word0 zero");

    // R1 held request is acknowledged every other cycle
    @(negedge clk); wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = 12'h004;
    @(negedge clk); chk(wb_ack === 1, "R1 first ack", {31'd0, wb_ack}, 1);
    @(negedge clk); chk(wb_ack === 0, "R1 ack one cycle", {31'd0, wb_ack}, 0);
    @(negedge clk); chk(wb_ack === 1, "R1 re-ack held req", {31'd0, wb_ack}, 1);
    wb_stb = 0;
    @(negedge clk); @(negedge clk);
    chk(wb_ack === 0, "R1 no ack without stb", {31'd0, wb_ack}, 0);
    wb_cyc = 0;

    // R2 R3 buffers with random top bytes and random low address bits
    for (int i = 0; i < 64; i++) begin
      wr({2'b00, 2'd1, i[5:0], 2'(($urandom))}, $urandom);
      wr({2'b00, 2'd2, i[5:0], 2'(($urandom))}, $urandom);
    end
    for (int i = 0; i < 40; i++)
      wr({2'b00, 2'(1 + $urandom % 2), 6'($urandom), 2'($urandom)}, $urandom);
    for (int i = 0; i < 64; i++) begin
      rd_chk({2'b00, 2'd1, i[5:0], 2'($urandom)}, "R3 R2 image readback");
      rd_chk({2'b00, 2'd2, i[5:0], 2'($urandom)}, "R3 R2 kernel readback");
    end
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      eng_img_addr = 6'($urandom); eng_krn_addr = 6'($urandom);
      #1;
      chk(eng_img_data === img_m[eng_img_addr], "R3 engine image port", {8'd0, eng_img_data}, {8'd0, img_m[eng_img_addr]});
      chk(eng_krn_data === krn_m[eng_krn_addr], "R3 engine kernel port", {8'd0, eng_krn_data}, {8'd0, krn_m[eng_krn_addr]});
    end

    // R4 R5 configuration words
    for (int i = 0; i < 6; i++) begin
      wr(12'h004, $urandom);
      wr(12'h008, $urandom);
      @(negedge clk);
      cfg_chk();
      rd_chk(12'h004, "R4 word1 readback");
      rd_chk(12'h008, "R5 word2 readback");
    end
    wr(12'h004, 32'hFFFF_FFFF); wr(12'h008, 32'hFFFF_FFFF);
    @(negedge clk); cfg_chk();

    // R6 start sequencing
    wr(12'h000, 32'h4);
    @(negedge clk); chk(eng_start === 0, "R6 pulse ends", {31'd0, eng_start}, 0);
    rd_chk(12'h000, "R6 start readback");
    wr(12'h000, 32'h4);
    wr(12'h000, 32'h0);
    rd_chk(12'h000, "R6 start cleared");
    wr(12'h000, 32'h4);

    // R7 done flag
    done_pulse();
    rd_chk(12'h000, "R7 done set");
    wr(12'h000, 32'h0);
    rd_chk(12'h000, "R7 done survives write of zero");

    // R8 soft reset
    wr(12'h000, 32'h2);
    chk(eng_srst === 1, "R8 srst level", {31'd0, eng_srst}, 1);
    rd_chk(12'h000, "R8 done cleared");
    done_pulse();
    rd_chk(12'h000, "R8 done ignored in srst");
    wr(12'h000, 32'h0);
    chk(eng_srst === 0, "R8 srst released", {31'd0, eng_srst}, 0);
    wr(12'h000, 32'h1);
    rd_chk(12'h000, "R7 done bit not writable");

    // R9 result buffer
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      eng_res_we = 1; eng_res_addr = i[5:0]; eng_res_data = 8'($urandom);
      res_m[i] = eng_res_data;
    end
    @(negedge clk); eng_res_we = 0;
    for (int i = 0; i < 16; i++) rd_chk({4'b0011, 6'($urandom), 2'b00}, "R9 result readback");
    wr(12'h314, 32'hFFFF_FFFF);
    rd_chk(12'h314, "R9 bus write ignored");

    // R10 unmapped accesses
    rd_chk(12'h40C, "R10 high read zero");
    wr(12'h50C, 32'h00AB_CDEF);
    rd_chk(12'h10C, "R10 high write no alias");
    wr(12'h00C, 32'hFFFF_FFFF);
    rd_chk(12'h00C, "R10 reg word3 zero");
    rd_chk(12'h004, "R10 word1 untouched");
    @(negedge clk); cfg_chk();
    wr(12'hC00, 32'h4);
    chk(saw_start === 0, "R10 no start from unmapped", {31'd0, saw_start}, 0);
    rd_chk(12'h000, "R10 word0 untouched");

    finish_up();
  end
endmodule